// File: doc/BRIEF.md
# Sixteen-Pin GPIO Port with Atomic Bit Aliases

This block is one general-purpose I/O port with sixteen pins. Software reaches it through a simple 32-bit register bus. Each pin has a direction bit. When that bit is 1 the port drives the pin from its output-data bit. When it is 0 the pin floats and the port only samples it.

Three write-only alias registers change output bits without a read-modify-write sequence:
- the set alias forces bits to 1,
- the clear alias forces bits to 0,
- the toggle alias inverts bits.

In each case only the bits written as 1 are touched. An input register shows the pin levels after a two-flop synchronizer. Bits 16 to 31 of every register are inert.

The bus is a single request port with per-byte write strobes. A read returns its data one cycle after the request, marked by a response strobe. The register word index sits in address bits [4:2]:

| Word | Register |
|------|----------|
| 0 | direction |
| 1 | output data |
| 2 | set alias |
| 3 | clear alias |
| 4 | toggle alias |
| 5 | input levels |

Other addresses, and addresses with bits [1:0] not zero, are ignored on write and read as zero.

Top module: `gpio_port16`

## Requirements
- R1: After reset the direction and output-data registers are zero, so every output-enable is 0 and every pin output is 0.
- R2: Writing word 0 sets the direction; `pin_oe[i]` equals direction bit i from the cycle after the write.
- R3: Writing word 1 sets the output data. `pin_o[i]` equals output bit i from the cycle after the write, and reading word 1 returns it.
- R4: A write to word 2 sets to 1 every output bit whose data bit is 1 and leaves all other output and direction bits unchanged.
- R5: A write to word 3 clears to 0 every output bit whose data bit is 1 and leaves all other bits unchanged.
- R6: A write to word 4 inverts every output bit whose data bit is 1 and leaves all other bits unchanged.
- R7: Reads of words 2, 3 and 4, and of any unmapped or misaligned address, return zero. Writes to unmapped addresses change nothing.
- R8: Data bits 16 to 31 and strobes 2 and 3 have no effect on any write. Bits 16 to 31 of every read are zero.
- R9: Strobe 0 gates pins 0..7 and strobe 1 gates pins 8..15, for direction, output and alias writes alike. Pins in an unstrobed byte keep their value.
- R10: Reading word 5 returns the level each pin had two clock edges before the read is captured, through a two-flop synchronizer. A pin configured as output shows its own driven level.
- R11: A read request captured at clock edge k gives `rsp_valid` = 1 and the data after edge k, for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_req | input | 1 | Access request, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address; word index in bits [4:2] |
| bus_wdata | input | 32 | Write data |
| bus_be | input | 4 | Byte write strobes |
| rsp_valid | output | 1 | Read data valid, one cycle after a read request |
| rsp_rdata | output | 32 | Read data |
| pin_i | input | 16 | Pin levels seen at the pads |
| pin_o | output | 16 | Pin output values |
| pin_oe | output | 16 | Pin output enables (1 = drive) |

## Verification
The collision that matters is an alias write that changes a pin driving itself, while the input register is being read in the immediately following cycle. The bench loops every output-enabled pin back onto `pin_i`. It toggles such a pin and reads word 5 right away, and expects the old level because the synchronizer has not caught up yet. It then reads again two idle cycles later and expects the new level. A scoreboard queue holds the expected read words in request order, and these are judged against `rsp_rdata` whenever `rsp_valid` rises.

// File: rtl/gpio_pkg.sv
// Shared definitions for the GPIO port: register word indices and bus sizes.
// Assumes a 32-bit register bus with byte strobes.
package gpio_pkg;
    localparam int BUS_W = 32;
    localparam int BE_W  = BUS_W / 8;

    typedef enum logic [2:0] {
        RI_DIR = 3'd0,
        RI_OUT = 3'd1,
        RI_SET = 3'd2,
        RI_CLR = 3'd3,
        RI_TGL = 3'd4,
        RI_IN  = 3'd5
    } reg_idx_e;
endpackage

// File: rtl/gpio_ctrl.sv
// Direction and output-data state, with set/clear/toggle alias updates.
// Assumes wr_en is already qualified by a valid address, and that
// bit_en is the byte strobes expanded to one enable per pin.
module gpio_ctrl
    import gpio_pkg::*;
#(
    parameter int NPINS = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  reg_idx_e         idx,
    input  logic [NPINS-1:0] wbits,
    input  logic [NPINS-1:0] bit_en,
    output logic [NPINS-1:0] dir_q,
    output logic [NPINS-1:0] out_q
);
    logic [NPINS-1:0] hit_mask;

    // Bits an alias write acts on: written as 1 and inside a strobed byte.
    always_comb hit_mask = wbits & bit_en;

    // Register update for plain and alias writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q <= '0;
            out_q <= '0;
        end else if (wr_en) begin
            case (idx)
                RI_DIR:  dir_q <= (dir_q & ~bit_en) | (wbits & bit_en);
                RI_OUT:  out_q <= (out_q & ~bit_en) | (wbits & bit_en);
                RI_SET:  out_q <= out_q | hit_mask;
                RI_CLR:  out_q <= out_q & ~hit_mask;
                RI_TGL:  out_q <= out_q ^ hit_mask;
                default: ;
            endcase
        end
    end

    // R1: both registers are zero in the cycle after reset.
    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (dir_q == '0) && (out_q == '0));

    // R4: a set write raises every selected bit and leaves direction alone.
    p_set_bits_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && idx == RI_SET)
        |=> ((out_q & $past(hit_mask)) == $past(hit_mask)) && $stable(dir_q));

    // R5: a clear write lowers every selected bit.
    p_clr_bits_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && idx == RI_CLR) |=> ((out_q & $past(hit_mask)) == '0));

    // R6: a toggle write changes exactly the selected bits.
    p_tgl_bits_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && idx == RI_TGL) |=> ((out_q ^ $past(out_q)) == $past(hit_mask)));

    // R7: without a valid write, no state changes.
    p_idle_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(out_q) && $stable(dir_q));
endmodule

// File: rtl/gpio_insync.sv
// Two-flop synchronizer that brings the asynchronous pin levels into the
// clock domain. Assumes each pin is independent (no multi-bit coherency).
module gpio_insync #(
    parameter int NPINS = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] pin_i,
    output logic [NPINS-1:0] lvl_q
);
    logic [NPINS-1:0] meta_q;
    logic [1:0]       age_q;

    // First and second synchronizer stages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            lvl_q  <= '0;
        end else begin
            meta_q <= pin_i;
            lvl_q  <= meta_q;
        end
    end

    // Cycles since reset, saturating at 2; only gates the assertion below.
    always_ff @(posedge clk) begin
        if (!rst_n)           age_q <= '0;
        else if (age_q != 2'd2) age_q <= age_q + 2'd1;
    end

    // R10: the synchronized level is the pin level two edges earlier.
    p_two_stage_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q == 2'd2) |-> (lvl_q == $past(pin_i, 2)));
endmodule

// File: rtl/gpio_rdmux.sv
// Registered read path: selects one register and zero-extends it to the bus.
// Assumes rd_en is qualified by a valid, aligned address.
module gpio_rdmux
    import gpio_pkg::*;
#(
    parameter int NPINS = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_req,
    input  logic             rd_en,
    input  reg_idx_e         idx,
    input  logic [NPINS-1:0] dir_q,
    input  logic [NPINS-1:0] out_q,
    input  logic [NPINS-1:0] lvl_q,
    output logic             rsp_valid,
    output logic [BUS_W-1:0] rsp_rdata
);
    logic [NPINS-1:0] pick;

    // Select the readable register; alias and unmapped words read zero.
    always_comb begin
        pick = '0;
        if (rd_en) begin
            case (idx)
                RI_DIR:  pick = dir_q;
                RI_OUT:  pick = out_q;
                RI_IN:   pick = lvl_q;
                default: pick = '0;
            endcase
        end
    end

    // Capture the response one cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= rd_req;
            rsp_rdata <= rd_req ? {{(BUS_W-NPINS){1'b0}}, pick} : '0;
        end
    end

    // R8: the upper half of every response is zero.
    p_upper_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_rdata[BUS_W-1:NPINS] == '0));

    // R7: reads of alias words return zero.
    p_alias_rd_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && (idx == RI_SET || idx == RI_CLR || idx == RI_TGL))
        |=> (rsp_rdata == '0));

    // R11: the response strobe follows the request by one cycle.
    p_rsp_timing_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> rsp_valid);
endmodule

// File: rtl/gpio_port16.sv
// Top of the GPIO port: decodes the register bus, expands byte strobes to
// pin enables, and ties the control, synchronizer and read path together.
// Assumes one access per cycle and NPINS <= 16 (pins fit in strobes 0..1).
module gpio_port16
    import gpio_pkg::*;
#(
    parameter int NPINS = 16,
    parameter int AW    = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_req,
    input  logic             bus_we,
    input  logic [AW-1:0]    bus_addr,
    input  logic [BUS_W-1:0] bus_wdata,
    input  logic [BE_W-1:0]  bus_be,
    output logic             rsp_valid,
    output logic [BUS_W-1:0] rsp_rdata,
    input  logic [NPINS-1:0] pin_i,
    output logic [NPINS-1:0] pin_o,
    output logic [NPINS-1:0] pin_oe
);
    localparam int IDX_LO = 2;
    localparam int IDX_HI = IDX_LO + 2;

    reg_idx_e         idx;
    logic             addr_ok;
    logic             wr_en;
    logic             rd_req;
    logic             rd_en;
    logic [NPINS-1:0] bit_en;
    logic [NPINS-1:0] dir_q;
    logic [NPINS-1:0] out_q;
    logic [NPINS-1:0] lvl_q;

    // Address decode: aligned, in range and a defined word index.
    always_comb begin
        idx     = reg_idx_e'(bus_addr[IDX_HI:IDX_LO]);
        addr_ok = (bus_addr[1:0] == 2'b00)
               && (bus_addr[AW-1:IDX_HI+1] == '0)
               && (bus_addr[IDX_HI:IDX_LO] <= 3'(RI_IN));
        wr_en   = bus_req && bus_we && addr_ok;
        rd_req  = bus_req && !bus_we;
        rd_en   = rd_req && addr_ok;
    end

    // One enable per pin from the strobe of the byte it lives in.
    for (genvar b = 0; b < NPINS; b++) begin : g_bit_en
        assign bit_en[b] = bus_be[b / 8];
    end

    gpio_ctrl #(.NPINS(NPINS)) u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .idx    (idx),
        .wbits  (bus_wdata[NPINS-1:0]),
        .bit_en (bit_en),
        .dir_q  (dir_q),
        .out_q  (out_q)
    );

    gpio_insync #(.NPINS(NPINS)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .pin_i (pin_i),
        .lvl_q (lvl_q)
    );

    gpio_rdmux #(.NPINS(NPINS)) u_rd (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_req    (rd_req),
        .rd_en     (rd_en),
        .idx       (idx),
        .dir_q     (dir_q),
        .out_q     (out_q),
        .lvl_q     (lvl_q),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata)
    );

    assign pin_o  = out_q;
    assign pin_oe = dir_q;

    // R2: direction register follows a strobed write of word 0.
    p_dir_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && idx == RI_DIR && bus_be[0])
        |=> (pin_oe[7:0] == $past(bus_wdata[7:0])));

    // R9: a write with no low strobes leaves the low pins untouched.
    p_strobe_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_we && bus_be[1:0] == 2'b00)
        |=> $stable(pin_o) && $stable(pin_oe));
endmodule

// File: tb/tb_gpio_port16.sv
// Scoreboard bench: the driver pushes expected read words into a queue,
// and the monitor pops and compares them whenever a response arrives.
module tb_gpio_port16;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_req = 1'b0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [3:0]  bus_be = '0;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;
    logic [15:0] pin_i;
    logic [15:0] pin_o;
    logic [15:0] pin_oe;
    logic [15:0] ext_lvl = '0;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [31:0] exp_q[$];
    string       tag_q[$];
    logic [15:0] m_dir = '0;
    logic [15:0] m_out = '0;

    always #2 clk = ~clk;

    // Loopback: driven pins see their own output, others see the external level.
    assign pin_i = (pin_oe & pin_o) | (~pin_oe & ext_lvl);

    gpio_port16 dut (
        .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_be(bus_be),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .pin_i(pin_i), .pin_o(pin_o), .pin_oe(pin_oe)
    );

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] be_mask(logic [3:0] be);
        return {{8{be[1]}}, {8{be[0]}}};
    endfunction

    // Driver: one write cycle, with the reference model updated per the requirements.
    task automatic wr(logic [7:0] a, logic [31:0] d, logic [3:0] be);
        logic [15:0] m;
        logic [15:0] h;
        m = be_mask(be);
        h = d[15:0] & m;
        bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d; bus_be = be;
        @(negedge clk);
        bus_req = 1'b0; bus_we = 1'b0;
        case (a)
            8'h00: m_dir = (m_dir & ~m) | h;
            8'h04: m_out = (m_out & ~m) | h;
            8'h08: m_out = m_out | h;
            8'h0C: m_out = m_out & ~h;
            8'h10: m_out = m_out ^ h;
            default: ;
        endcase
    endtask

    // Driver: one read cycle; pushes the expected word for the monitor.
    task automatic rd(logic [7:0] a, logic [31:0] exp, string tag);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        bus_req = 1'b1; bus_we = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_req = 1'b0;
    endtask

    function automatic logic [31:0] pads();
        return {16'h0, (m_dir & m_out) | (~m_dir & ext_lvl)};
    endfunction

    // Monitor: compare each response with the head of the scoreboard (R11).
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (exp_q.size() == 0) begin
                check("R11 unexpected response", 32'h1, 32'h0);
            end else begin
                check(tag_q.pop_front(), rsp_rdata, exp_q.pop_front());
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state at the pins and in the registers.
        check("R1 pin_oe after reset", {16'h0, pin_oe}, 32'h0);
        check("R1 pin_o after reset", {16'h0, pin_o}, 32'h0);
        rd(8'h00, 32'h0, "R1 dir read");
        rd(8'h04, 32'h0, "R1 out read");

        // R2, R3: plain direction and output writes.
        wr(8'h00, 32'h0000_00FF, 4'b0011);
        check("R2 pin_oe", {16'h0, pin_oe}, 32'h0000_00FF);
        wr(8'h04, 32'h0000_A5C3, 4'b0011);
        check("R3 pin_o", {16'h0, pin_o}, 32'h0000_A5C3);
        rd(8'h04, {16'h0, m_out}, "R3 out readback");
        rd(8'h00, {16'h0, m_dir}, "R2 dir readback");

        // R4, R5, R6: alias writes touch only bits written as 1.
        wr(8'h08, 32'h0000_0F0F, 4'b0011);
        check("R4 set", {16'h0, pin_o}, {16'h0, m_out});
        check("R4 dir untouched", {16'h0, pin_oe}, 32'h0000_00FF);
        wr(8'h0C, 32'h0000_8181, 4'b0011);
        check("R5 clear", {16'h0, pin_o}, {16'h0, m_out});
        wr(8'h10, 32'h0000_FFFF, 4'b0011);
        check("R6 toggle", {16'h0, pin_o}, {16'h0, m_out});
        wr(8'h10, 32'h0000_0000, 4'b0011);
        check("R6 toggle zero", {16'h0, pin_o}, {16'h0, m_out});

        // R7: alias and unmapped reads are zero; unmapped and misaligned writes are ignored.
        rd(8'h08, 32'h0, "R7 set reads zero");
        rd(8'h0C, 32'h0, "R7 clear reads zero");
        rd(8'h10, 32'h0, "R7 toggle reads zero");
        rd(8'h18, 32'h0, "R7 unmapped reads zero");
        wr(8'h18, 32'h0000_FFFF, 4'b1111);
        wr(8'h05, 32'h0000_FFFF, 4'b1111);
        check("R7 ignored writes out", {16'h0, pin_o}, {16'h0, m_out});
        check("R7 ignored writes dir", {16'h0, pin_oe}, {16'h0, m_dir});

        // R8: upper data bits and upper strobes are inert.
        wr(8'h04, 32'hFFFF_0000, 4'b1100);
        check("R8 upper strobes inert", {16'h0, pin_o}, {16'h0, m_out});
        wr(8'h04, 32'h5A5A_1234, 4'b1111);
        rd(8'h04, 32'h0000_1234, "R8 upper bits read zero");

        // R9: each byte strobe gates its own eight pins.
        wr(8'h04, 32'h0000_FFFF, 4'b0010);
        check("R9 high byte only", {16'h0, pin_o}, 32'h0000_FF34);
        wr(8'h08, 32'h0000_FFFF, 4'b0001);
        check("R9 set low byte only", {16'h0, pin_o}, 32'h0000_FFFF);
        wr(8'h00, 32'h0000_FF00, 4'b0010);
        check("R9 dir high byte", {16'h0, pin_oe}, 32'h0000_FFFF);
        wr(8'h00, 32'h0000_0000, 4'b0001);
        check("R9 dir low byte", {16'h0, pin_oe}, 32'h0000_FF00);

        // R10: input register with external levels on input pins.
        ext_lvl = 16'h00A6;
        repeat (3) @(negedge clk);
        rd(8'h14, pads(), "R10 input levels");
        ext_lvl = 16'h0059;
        repeat (3) @(negedge clk);
        rd(8'h14, pads(), "R10 input levels second pattern");

        // R10 vs R6: toggle a looped-back pin, then read at once and later.
        wr(8'h10, 32'h0000_8000, 4'b0010);
        rd(8'h14, {16'h0, (m_dir & (m_out ^ 16'h8000)) | (~m_dir & ext_lvl)},
           "R10 read right after toggle shows old level");
        repeat (2) @(negedge clk);
        rd(8'h14, pads(), "R10 read after sync shows new level");

        repeat (3) @(negedge clk);
        check("R11 scoreboard drained", exp_q.size(), 32'h0);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule